// File: doc/BRIEF.md
# Paged 32-bit Register Bridge for a 16-bit Management Bus

This block sits behind an MDIO slave that has already decoded the serial frame. It turns the decoded 16-bit clause-22 style accesses (PHY address, register number, write data, read or write strobe) into single 32-bit accesses on a simple internal register bus. The internal byte address is spread across three places. A page register holds the top bits. The low PHY address bits supply a middle field. The MDIO register number, with its lowest bit dropped, supplies the low word-select bits.

Each 32-bit word occupies an even/odd pair of MDIO registers. The even register holds data bits 15:0 and the odd register holds bits 31:16. Software writes the low half first and then the high half; the bridge holds the low half and issues one bus write once the high half arrives. Software also reads the low half first. That read fetches and latches the whole word, and the following high-half read is served from the latch, so the two halves always come from the same bus read.

Top module: `mdio_page_bridge`

## Requirements
- R1: After reset the page is 0, the low-half write buffer and read latch are 0, and neither `bus_req` nor `mdio_rvalid` is asserted.
- R2: A write strobe to PHY address 0x18, register 0, loads `mdio_wdata[9:0]` into the page; the upper write bits are dropped. A read strobe to the same location returns the page, zero-extended to 16 bits, with `mdio_rvalid` one cycle after the strobe.
- R3: A strobe whose PHY address is outside 0x10..0x17 and that is not aimed at the page location (PHY 0x18, register 0) causes no bus access, no `mdio_rvalid` and no page change.
- R4: Every bus access uses the byte address {page[9:0], phy[2:0], regnum[4:1], 2'b00}, so 19 bits in all.
- R5: A write strobe to a data PHY with an even register number (regnum bit 0 = 0) stores the 16-bit data as the low half and starts no bus access. The stored half stays until the next such write.
- R6: A write strobe to a data PHY with an odd register number drives `bus_req` and `bus_we` for one cycle, in the cycle after the strobe, with `bus_wdata` = {strobe data, stored low half}.
- R7: A read strobe to a data PHY with an even register number drives a one-cycle bus read (`bus_req` high, `bus_we` low) in the cycle after the strobe. In the cycle after that, `mdio_rvalid` is high and `mdio_rdata` holds `bus_rdata[15:0]`.
- R8: A read strobe to a data PHY with an odd register number starts no bus access. One cycle later it returns bits 31:16 of the word latched by the most recent low-half read, even if the register has changed since.
- R9: The page keeps its value across all data accesses and ignored strobes.
- R10: `bus_req` is high only in a cycle that directly follows an accepted strobe, and for a single cycle per strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mdio_req | input | 1 | One-cycle strobe for a decoded management access |
| mdio_we | input | 1 | 1 = write, 0 = read |
| mdio_phy | input | 5 | PHY address of the access |
| mdio_regad | input | 5 | Register number of the access |
| mdio_wdata | input | 16 | Write data |
| mdio_rvalid | output | 1 | Read data valid, one cycle wide |
| mdio_rdata | output | 16 | Read data returned to the management bus |
| bus_req | output | 1 | Internal bus access strobe |
| bus_we | output | 1 | Internal bus write enable |
| bus_addr | output | 19 | Internal byte address |
| bus_wdata | output | 32 | Internal write data |
| bus_rdata | input | 32 | Internal read data, valid in the cycle `bus_req` is high |

## Verification
The bench targets how the address is split. It uses pages 0, 0x3FF and a mixed value, together with the highest register pair, so a swapped field or a register number that keeps bit 0 shows up as a wrong write or read address. It changes the bus word between the low and high reads: a bridge that re-reads on the high half returns the new upper bits instead of the latched ones. It issues a high-half write with no fresh low half, which exposes a buffer that clears after use. It also strobes PHY 0x18 at a non-zero register and PHYs next to the data window; a loose decode then either moves the page or emits a stray bus cycle.

// File: rtl/mdio_bridge_pkg.sv
package mdio_bridge_pkg;

    localparam int unsigned PHY_W_DEF  = 5;
    localparam int unsigned REG_W_DEF  = 5;
    localparam int unsigned SUB_W_DEF  = 3;
    localparam int unsigned PAGE_W_DEF = 10;
    localparam int unsigned HALF_W_DEF = 16;

    typedef enum logic [2:0] {
        ACC_NONE    = 3'd0,
        ACC_PAGE_WR = 3'd1,
        ACC_PAGE_RD = 3'd2,
        ACC_WR_LO   = 3'd3,
        ACC_WR_HI   = 3'd4,
        ACC_RD_LO   = 3'd5,
        ACC_RD_HI   = 3'd6
    } acc_kind_e;

endpackage

// File: rtl/mdio_bridge_decode.sv
module mdio_bridge_decode
    import mdio_bridge_pkg::*;
#(
    parameter int unsigned PHY_W  = PHY_W_DEF,
    parameter int unsigned REG_W  = REG_W_DEF,
    parameter int unsigned SUB_W  = SUB_W_DEF,
    parameter int unsigned PAGE_W = PAGE_W_DEF,
    parameter logic [PHY_W-1:0] PAGE_PHY = 5'h18,
    parameter logic [PHY_W-1:0] DATA_PHY = 5'h10,
    localparam int unsigned BYTE_LSB = 2,
    localparam int unsigned ADDR_W   = PAGE_W + SUB_W + (REG_W - 1) + BYTE_LSB
) (
    input  logic              req,
    input  logic              we,
    input  logic [PHY_W-1:0]  phy,
    input  logic [REG_W-1:0]  regad,
    input  logic [PAGE_W-1:0] page,
    output acc_kind_e         kind,
    output logic [ADDR_W-1:0] addr
);

    logic hit_page;
    logic hit_data;

    always_comb begin
        hit_page = (phy == PAGE_PHY) && (regad == '0);
        hit_data = (phy[PHY_W-1:SUB_W] == DATA_PHY[PHY_W-1:SUB_W]);
        kind     = ACC_NONE;
        if (req) begin
            if (hit_page) begin
                kind = we ? ACC_PAGE_WR : ACC_PAGE_RD;
            end else if (hit_data) begin
                if (we) begin
                    kind = regad[0] ? ACC_WR_HI : ACC_WR_LO;
                end else begin
                    kind = regad[0] ? ACC_RD_HI : ACC_RD_LO;
                end
            end
        end
        // Word-aligned byte address: register bit 0 only selects the half.
        addr = {page, phy[SUB_W-1:0], regad[REG_W-1:1], {BYTE_LSB{1'b0}}};
    end

endmodule

// File: rtl/mdio_bridge_page.sv
module mdio_bridge_page
    import mdio_bridge_pkg::*;
#(
    parameter int unsigned PAGE_W = PAGE_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  acc_kind_e         kind,
    input  logic [PAGE_W-1:0] wdata,
    output logic [PAGE_W-1:0] page
);

    typedef struct packed {
        logic [PAGE_W-1:0] page;
    } page_st_t;

    page_st_t st_d;
    page_st_t st_q;

    always_comb begin
        st_d = st_q;
        if (kind == ACC_PAGE_WR) begin
            st_d.page = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign page = st_q.page;

endmodule

// File: rtl/mdio_bridge_datapath.sv
module mdio_bridge_datapath
    import mdio_bridge_pkg::*;
#(
    parameter int unsigned HALF_W = HALF_W_DEF,
    parameter int unsigned PAGE_W = PAGE_W_DEF,
    parameter int unsigned ADDR_W = 19,
    localparam int unsigned WORD_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  acc_kind_e         kind,
    input  logic [ADDR_W-1:0] addr,
    input  logic [HALF_W-1:0] wdata,
    input  logic [PAGE_W-1:0] page,
    input  logic [WORD_W-1:0] bus_rdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [WORD_W-1:0] bus_wdata,
    output logic              rvalid,
    output logic [HALF_W-1:0] rdata
);

    typedef struct packed {
        logic              bus_req;
        logic              bus_we;
        logic [ADDR_W-1:0] bus_addr;
        logic [WORD_W-1:0] bus_wdata;
        logic [HALF_W-1:0] lo_buf;
        logic [WORD_W-1:0] rd_word;
        logic              rd_pend;
        logic              rvalid;
        logic [HALF_W-1:0] rdata;
    } dp_st_t;

    dp_st_t st_d;
    dp_st_t st_q;

    always_comb begin
        st_d         = st_q;
        st_d.bus_req = 1'b0;
        st_d.rvalid  = 1'b0;

        // Finish an outstanding low-half read: keep the whole word.
        if (st_q.rd_pend) begin
            st_d.rd_pend = 1'b0;
            st_d.rd_word = bus_rdata;
            st_d.rvalid  = 1'b1;
            st_d.rdata   = bus_rdata[HALF_W-1:0];
        end

        unique case (kind)
            ACC_PAGE_RD: begin
                st_d.rvalid = 1'b1;
                st_d.rdata  = {{(HALF_W - PAGE_W){1'b0}}, page};
            end
            ACC_WR_LO: begin
                st_d.lo_buf = wdata;
            end
            ACC_WR_HI: begin
                st_d.bus_req   = 1'b1;
                st_d.bus_we    = 1'b1;
                st_d.bus_addr  = addr;
                st_d.bus_wdata = {wdata, st_q.lo_buf};
            end
            ACC_RD_LO: begin
                st_d.bus_req  = 1'b1;
                st_d.bus_we   = 1'b0;
                st_d.bus_addr = addr;
                st_d.rd_pend  = 1'b1;
            end
            ACC_RD_HI: begin
                st_d.rvalid = 1'b1;
                st_d.rdata  = st_q.rd_word[WORD_W-1:HALF_W];
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_req   = st_q.bus_req;
    assign bus_we    = st_q.bus_we;
    assign bus_addr  = st_q.bus_addr;
    assign bus_wdata = st_q.bus_wdata;
    assign rvalid    = st_q.rvalid;
    assign rdata     = st_q.rdata;

endmodule

// File: rtl/mdio_page_bridge.sv
module mdio_page_bridge
    import mdio_bridge_pkg::*;
#(
    parameter int unsigned PHY_W  = PHY_W_DEF,
    parameter int unsigned REG_W  = REG_W_DEF,
    parameter int unsigned SUB_W  = SUB_W_DEF,
    parameter int unsigned PAGE_W = PAGE_W_DEF,
    parameter int unsigned HALF_W = HALF_W_DEF,
    parameter logic [PHY_W-1:0] PAGE_PHY = 5'h18,
    parameter logic [PHY_W-1:0] DATA_PHY = 5'h10,
    localparam int unsigned ADDR_W = PAGE_W + SUB_W + (REG_W - 1) + 2,
    localparam int unsigned WORD_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mdio_req,
    input  logic              mdio_we,
    input  logic [PHY_W-1:0]  mdio_phy,
    input  logic [REG_W-1:0]  mdio_regad,
    input  logic [HALF_W-1:0] mdio_wdata,
    output logic              mdio_rvalid,
    output logic [HALF_W-1:0] mdio_rdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [WORD_W-1:0] bus_wdata,
    input  logic [WORD_W-1:0] bus_rdata
);

    acc_kind_e         kind;
    logic [ADDR_W-1:0] acc_addr;
    logic [PAGE_W-1:0] page_val;

    mdio_bridge_decode #(
        .PHY_W    (PHY_W),
        .REG_W    (REG_W),
        .SUB_W    (SUB_W),
        .PAGE_W   (PAGE_W),
        .PAGE_PHY (PAGE_PHY),
        .DATA_PHY (DATA_PHY)
    ) u_decode (
        .req   (mdio_req),
        .we    (mdio_we),
        .phy   (mdio_phy),
        .regad (mdio_regad),
        .page  (page_val),
        .kind  (kind),
        .addr  (acc_addr)
    );

    mdio_bridge_page #(
        .PAGE_W (PAGE_W)
    ) u_page (
        .clk   (clk),
        .rst_n (rst_n),
        .kind  (kind),
        .wdata (mdio_wdata[PAGE_W-1:0]),
        .page  (page_val)
    );

    mdio_bridge_datapath #(
        .HALF_W (HALF_W),
        .PAGE_W (PAGE_W),
        .ADDR_W (ADDR_W)
    ) u_datapath (
        .clk       (clk),
        .rst_n     (rst_n),
        .kind      (kind),
        .addr      (acc_addr),
        .wdata     (mdio_wdata),
        .page      (page_val),
        .bus_rdata (bus_rdata),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .rvalid    (mdio_rvalid),
        .rdata     (mdio_rdata)
    );

endmodule

// File: rtl/mdio_bridge_checker.sv
module mdio_bridge_checker #(
    parameter int unsigned PHY_W  = 5,
    parameter int unsigned REG_W  = 5,
    parameter int unsigned SUB_W  = 3,
    parameter int unsigned PAGE_W = 10,
    parameter int unsigned HALF_W = 16,
    parameter logic [PHY_W-1:0] PAGE_PHY = 5'h18,
    parameter logic [PHY_W-1:0] DATA_PHY = 5'h10,
    localparam int unsigned ADDR_W = PAGE_W + SUB_W + (REG_W - 1) + 2,
    localparam int unsigned WORD_W = 2 * HALF_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mdio_req,
    input logic              mdio_we,
    input logic [PHY_W-1:0]  mdio_phy,
    input logic [REG_W-1:0]  mdio_regad,
    input logic [HALF_W-1:0] mdio_wdata,
    input logic              mdio_rvalid,
    input logic [HALF_W-1:0] mdio_rdata,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [WORD_W-1:0] bus_wdata,
    input logic [WORD_W-1:0] bus_rdata,
    input logic [PAGE_W-1:0] page_val
);

    logic is_data;
    logic is_page;

    assign is_data = (mdio_phy[PHY_W-1:SUB_W] == DATA_PHY[PHY_W-1:SUB_W]);
    assign is_page = (mdio_phy == PAGE_PHY) && (mdio_regad == '0);

    a_r6_hi_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_req && mdio_we && is_data && mdio_regad[0])
        |=> (bus_req && bus_we && bus_wdata[WORD_W-1:HALF_W] == $past(mdio_wdata)));

    a_r5_lo_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_req && mdio_we && is_data && !mdio_regad[0]) |=> !bus_req);

    a_r7_rd_issue: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_req && !mdio_we && is_data && !mdio_regad[0]) |=> (bus_req && !bus_we));

    a_r7_rd_return: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && !mdio_req)
        |=> (mdio_rvalid && mdio_rdata == $past(bus_rdata[HALF_W-1:0])));

    a_r8_hi_rd_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_req && !mdio_we && is_data && mdio_regad[0]) |=> (!bus_req && mdio_rvalid));

    a_r3_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_req && !is_data && !is_page && !bus_req) |=> (!bus_req && !mdio_rvalid));

    a_r4_page_field: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (bus_addr[ADDR_W-1 -: PAGE_W] == page_val && bus_addr[1:0] == 2'b00));

    a_r9_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(mdio_req && mdio_we && is_page) |=> $stable(page_val));

    a_r10_req_origin: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> $past(mdio_req));

endmodule

bind mdio_page_bridge mdio_bridge_checker #(
    .PHY_W    (PHY_W),
    .REG_W    (REG_W),
    .SUB_W    (SUB_W),
    .PAGE_W   (PAGE_W),
    .HALF_W   (HALF_W),
    .PAGE_PHY (PAGE_PHY),
    .DATA_PHY (DATA_PHY)
) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .mdio_req    (mdio_req),
    .mdio_we     (mdio_we),
    .mdio_phy    (mdio_phy),
    .mdio_regad  (mdio_regad),
    .mdio_wdata  (mdio_wdata),
    .mdio_rvalid (mdio_rvalid),
    .mdio_rdata  (mdio_rdata),
    .bus_req     (bus_req),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .page_val    (page_val)
);

// File: tb/mdio_page_bridge_test.sv
`timescale 1ns/1ps
module mdio_page_bridge_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mdio_req = 1'b0;
    logic        mdio_we = 1'b0;
    logic [4:0]  mdio_phy = '0;
    logic [4:0]  mdio_regad = '0;
    logic [15:0] mdio_wdata = '0;
    logic        mdio_rvalid;
    logic [15:0] mdio_rdata;
    logic        bus_req;
    logic        bus_we;
    logic [18:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit running = 1'b0;

    // Bench shadow state and scoreboard queues
    logic [9:0]  sh_page = '0;
    logic [15:0] sh_lo = '0;
    logic [31:0] sh_word = '0;
    logic [31:0] mem [int];
    logic [18:0] exp_wa_q [$];
    logic [31:0] exp_wd_q [$];
    logic [18:0] exp_ra_q [$];
    logic [15:0] exp_rd_q [$];
    string       rd_tag_q [$];

    mdio_page_bridge uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .mdio_req    (mdio_req),
        .mdio_we     (mdio_we),
        .mdio_phy    (mdio_phy),
        .mdio_regad  (mdio_regad),
        .mdio_wdata  (mdio_wdata),
        .mdio_rvalid (mdio_rvalid),
        .mdio_rdata  (mdio_rdata),
        .bus_req     (bus_req),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata)
    );

    always #4 clk = ~clk;

    function automatic logic [31:0] model_read(input logic [18:0] a);
        if (mem.exists(int'(a))) return mem[int'(a)];
        return {13'h1D5, a};
    endfunction

    function automatic logic [18:0] exp_addr(input logic [9:0] pg,
                                             input logic [4:0] phy,
                                             input logic [4:0] ra);
        return {pg, phy[2:0], ra[4:1], 2'b00};
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Bus model: read data follows the registered address
    always @(negedge clk) bus_rdata <= model_read(bus_addr);

    // Monitor: pops expectations as results appear
    always @(negedge clk) begin
        if (rst_n && running) begin
            if (bus_req && bus_we) begin
                if (exp_wa_q.size() == 0) begin
                    check(1'b0, "R3 R5 R10 unexpected bus write", {45'd0, bus_addr}, 64'd0);
                end else begin
                    logic [18:0] ea;
                    logic [31:0] ed;
                    ea = exp_wa_q.pop_front();
                    ed = exp_wd_q.pop_front();
                    check(bus_addr == ea, "R4 R6 write address", {45'd0, bus_addr}, {45'd0, ea});
                    check(bus_wdata == ed, "R6 write data", {32'd0, bus_wdata}, {32'd0, ed});
                end
            end
            if (bus_req && !bus_we) begin
                if (exp_ra_q.size() == 0) begin
                    check(1'b0, "R3 R8 R10 unexpected bus read", {45'd0, bus_addr}, 64'd0);
                end else begin
                    logic [18:0] ea;
                    ea = exp_ra_q.pop_front();
                    check(bus_addr == ea, "R4 R7 read address", {45'd0, bus_addr}, {45'd0, ea});
                end
            end
            if (mdio_rvalid) begin
                if (exp_rd_q.size() == 0) begin
                    check(1'b0, "R3 unexpected read data", {48'd0, mdio_rdata}, 64'd0);
                end else begin
                    logic [15:0] er;
                    string t;
                    er = exp_rd_q.pop_front();
                    t  = rd_tag_q.pop_front();
                    check(mdio_rdata == er, t, {48'd0, mdio_rdata}, {48'd0, er});
                end
            end
        end
    end

    task automatic strobe(input logic we, input logic [4:0] phy,
                          input logic [4:0] ra, input logic [15:0] wd);
        @(negedge clk);
        mdio_req = 1'b1; mdio_we = we; mdio_phy = phy; mdio_regad = ra; mdio_wdata = wd;
        @(negedge clk);
        mdio_req = 1'b0; mdio_we = 1'b0; mdio_wdata = '0;
        repeat (4) @(negedge clk);
    endtask

    task automatic page_write(input logic [15:0] wd);
        sh_page = wd[9:0];
        strobe(1'b1, 5'h18, 5'h00, wd);
    endtask

    task automatic page_read(input string tag);
        exp_rd_q.push_back({6'd0, sh_page});
        rd_tag_q.push_back(tag);
        strobe(1'b0, 5'h18, 5'h00, 16'h0);
    endtask

    task automatic write_lo(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] wd);
        sh_lo = wd;
        strobe(1'b1, phy, ra, wd);
    endtask

    task automatic write_hi(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] wd);
        logic [18:0] a;
        a = exp_addr(sh_page, phy, ra);
        exp_wa_q.push_back(a);
        exp_wd_q.push_back({wd, sh_lo});
        mem[int'(a)] = {wd, sh_lo};
        strobe(1'b1, phy, ra, wd);
    endtask

    task automatic read_lo(input logic [4:0] phy, input logic [4:0] ra, input string tag);
        logic [18:0] a;
        a = exp_addr(sh_page, phy, ra);
        sh_word = model_read(a);
        exp_ra_q.push_back(a);
        exp_rd_q.push_back(sh_word[15:0]);
        rd_tag_q.push_back(tag);
        strobe(1'b0, phy, ra, 16'h0);
    endtask

    task automatic read_hi(input logic [4:0] phy, input logic [4:0] ra, input string tag);
        exp_rd_q.push_back(sh_word[31:16]);
        rd_tag_q.push_back(tag);
        strobe(1'b0, phy, ra, 16'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: outputs idle during and right after reset
        check(bus_req == 1'b0, "R1 bus_req in reset", {63'd0, bus_req}, 64'd0);
        check(mdio_rvalid == 1'b0, "R1 rvalid in reset", {63'd0, mdio_rvalid}, 64'd0);
        rst_n = 1'b1;
        running = 1'b1;
        repeat (2) @(negedge clk);
        check(bus_addr == '0 && bus_wdata == '0, "R1 bus outputs after reset",
              {13'd0, bus_addr, bus_wdata}, 64'd0);
        page_read("R1 page resets to zero");

        // R2: page load drops upper write bits, read back zero-extended
        page_write(16'hFEA5);
        page_read("R2 page readback");

        // R4 R5 R6: low buffered, high commits full word
        write_lo(5'h13, 5'd6, 16'h1234);
        write_hi(5'h13, 5'd7, 16'hABCD);

        // R3 R9: ignored strobes leave page and bus alone
        strobe(1'b1, 5'h18, 5'd1, 16'h0077);
        strobe(1'b1, 5'h05, 5'd0, 16'h0011);
        strobe(1'b1, 5'h19, 5'd0, 16'h0022);
        strobe(1'b1, 5'h0F, 5'd2, 16'h0033);
        strobe(1'b0, 5'h00, 5'd0, 16'h0);
        strobe(1'b0, 5'h18, 5'd3, 16'h0);
        page_read("R3 R9 page unchanged after ignored strobes");

        // R7 R8: read back the word written above
        read_lo(5'h13, 5'd6, "R7 low half of written word");
        read_hi(5'h13, 5'd7, "R8 high half of written word");

        // R8: high half comes from the latch even after the word changes
        read_lo(5'h17, 5'h1E, "R7 low half of untouched word");
        mem[int'(exp_addr(sh_page, 5'h17, 5'h1E))] = 32'h9999_8888;
        read_hi(5'h17, 5'h1F, "R8 latched high half after change");

        // R4 boundaries: page 0 and page all ones, top register pair
        page_write(16'h0000);
        write_lo(5'h10, 5'd0, 16'hC001);
        write_hi(5'h10, 5'd1, 16'hC002);
        page_write(16'h03FF);
        page_read("R2 page all ones");
        write_lo(5'h17, 5'h1E, 16'h5A5A);
        write_hi(5'h17, 5'h1F, 16'hA5A5);

        // R5: buffered low half is reused by a second high write
        write_hi(5'h17, 5'h1F, 16'h5555);
        read_lo(5'h17, 5'h1E, "R5 R7 low half reused");
        read_hi(5'h17, 5'h1F, "R6 R8 second high write");

        // R9: data traffic did not move the page
        page_read("R9 page after data accesses");

        repeat (6) @(negedge clk);
        check(exp_wa_q.size() == 0 && exp_ra_q.size() == 0 && exp_rd_q.size() == 0,
              "R10 all expected results seen",
              64'(exp_wa_q.size() + exp_ra_q.size() + exp_rd_q.size()), 64'd0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule